// File: doc/BRIEF.md
# Graphics Engine Interrupt Register Block

This block gathers the interrupts of a two-stage tile graphics engine and presents them to the host as a single interrupt line. It has three sources. Two are completion events, one for the renderer and one for the binner, and each arrives as a one-cycle pulse that is held in a pending latch. The third is the binner's out-of-memory condition. This source is a level: its pending bit keeps coming back while the binner has no overflow memory to work with.

Software uses a small word-addressed register bus. It acknowledges pending bits by writing ones to the status register. It turns individual sources on through a set-enable register and off through a clear-enable register, and both of these read back the same enable mask. It gives the binner a new overflow pool by writing a pool base address and a pool length. Once both have been written, the out-of-memory condition ends, and the next acknowledge clears that bit permanently.

Status and mask bit positions: bit 0 is render frame done, bit 1 is binning flush done, bit 2 is binner out of memory. Register word addresses: 0 is status, 1 is set-enable, 2 is clear-enable, 3 is pool address, 4 is pool size. Addresses 5 to 7 read as zero and ignore writes.

Top module: `gfx_irq_regs`

## Requirements
- R1: While reset is held, the status register, both enable registers, both pool registers and `irq` all read zero, and the out-of-memory condition is active.
- R2: A pulse on `ev_frame_done` sets status bit 0 and a pulse on `ev_flush_done` sets status bit 1, one clock later; each bit stays set until it is acknowledged.
- R3: Writing status (address 0) clears every pending bit written as 1 and leaves bits written as 0 unchanged. A cleared bit 0 or bit 1 stays clear until a new pulse arrives.
- R4: If an event pulse and an acknowledge of the same bit fall in the same cycle, the bit stays pending.
- R5: Writing address 1 turns on each source whose bit is 1. Zero bits leave the mask unchanged.
- R6: Writing address 2 turns off each source whose bit is 1. Zero bits leave the mask unchanged.
- R7: Reading address 1 or address 2 returns the enable mask in bits 2:0. Bits 31:3 of status and of both enable registers read zero, and addresses 5 to 7 read zero.
- R8: While the out-of-memory condition is active, status bit 2 reads 0 in the cycle right after it is acknowledged and is set again one cycle later.
- R9: The out-of-memory condition ends one clock after both pool registers (address 3 and address 4, in either order) have been written since it last began. After that, an acknowledge clears bit 2 until the next `ev_bin_oom` pulse, and that pulse restarts the condition.
- R10: The pool address and pool size registers read back the last full 32-bit value written to them.
- R11: `irq` is registered. One clock after any write or event, it is high exactly when the new pending bits ANDed with the new enable bits are nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Write strobe, one transfer per cycle |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ev_frame_done | input | 1 | Render frame done pulse |
| ev_flush_done | input | 1 | Binning flush done pulse |
| ev_bin_oom | input | 1 | Binner ran out of memory pulse |
| irq | output | 1 | Interrupt to host |

## Verification
The assertions assume that the write strobe, address and data are always known values, with at most one write per cycle, and that each event input is a pulse that means one occurrence per cycle it is high. The bench drives every input on the falling edge with defined values. It keeps out-of-memory pulses rare, so that the pool-refill path gets the chance to end the condition between them. Directed steps cover the same-cycle event and acknowledge collision, and the one-cycle dip of status bit 2 after it is acknowledged.

// File: rtl/gfx_irq_regs.sv
module gfx_irq_regs #(
  parameter int DW = 32,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          ev_frame_done,
  input  logic          ev_flush_done,
  input  logic          ev_bin_oom,
  output logic          irq
);
  localparam int NSRC = 3;
  localparam int OOM  = 2;
  localparam logic [AW-1:0] A_STAT = AW'(0);
  localparam logic [AW-1:0] A_ESET = AW'(1);
  localparam logic [AW-1:0] A_ECLR = AW'(2);
  localparam logic [AW-1:0] A_PADR = AW'(3);
  localparam logic [AW-1:0] A_PSIZ = AW'(4);

  logic [NSRC-1:0] pend_q, pend_d, en_q, en_d, evt, ack, eset, eclr;
  logic [DW-1:0]   pool_a_q, pool_s_q;
  logic            cond_q, got_a_q, got_s_q, got_a_n, got_s_n, irq_q;
  logic            wr_pa, wr_ps;

  assign evt   = {ev_bin_oom, ev_flush_done, ev_frame_done};
  assign ack   = (bus_wr && bus_addr == A_STAT) ? bus_wdata[NSRC-1:0] : '0;
  assign eset  = (bus_wr && bus_addr == A_ESET) ? bus_wdata[NSRC-1:0] : '0;
  assign eclr  = (bus_wr && bus_addr == A_ECLR) ? bus_wdata[NSRC-1:0] : '0;
  assign wr_pa = bus_wr && bus_addr == A_PADR;
  assign wr_ps = bus_wr && bus_addr == A_PSIZ;

  assign pend_d[OOM-1:0] = (pend_q[OOM-1:0] & ~ack[OOM-1:0]) | evt[OOM-1:0];
  assign pend_d[OOM]     = evt[OOM] | (~ack[OOM] & (pend_q[OOM] | cond_q));
  assign en_d            = (en_q | eset) & ~eclr;
  assign got_a_n         = got_a_q | wr_pa;
  assign got_s_n         = got_s_q | wr_ps;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      en_q   <= en_d;
      irq_q  <= |(pend_d & en_d);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q  <= 1'b1;
      got_a_q <= 1'b0;
      got_s_q <= 1'b0;
    end else if (evt[OOM]) begin
      cond_q  <= 1'b1;
      got_a_q <= 1'b0;
      got_s_q <= 1'b0;
    end else if (cond_q && got_a_n && got_s_n) begin
      cond_q  <= 1'b0;
      got_a_q <= 1'b0;
      got_s_q <= 1'b0;
    end else begin
      got_a_q <= got_a_n;
      got_s_q <= got_s_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pool_a_q <= '0;
      pool_s_q <= '0;
    end else begin
      if (wr_pa) pool_a_q <= bus_wdata;
      if (wr_ps) pool_s_q <= bus_wdata;
    end
  end

  always_comb begin
    case (bus_addr)
      A_STAT:         bus_rdata = DW'(pend_q);
      A_ESET, A_ECLR: bus_rdata = DW'(en_q);
      A_PADR:         bus_rdata = pool_a_q;
      A_PSIZ:         bus_rdata = pool_s_q;
      default:        bus_rdata = '0;
    endcase
  end

  assign irq = irq_q;

  // R4
  ev_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame_done |=> pend_q[0]);
  // R3
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_STAT && bus_wdata[1] && !ev_flush_done) |=> !pend_q[1]);
  // R5
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_ESET) |=> ((en_q & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0])));
  // R6
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_ECLR) |=> ((en_q & $past(bus_wdata[NSRC-1:0])) == '0));
  // R8
  oom_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_q && !(bus_wr && bus_addr == A_STAT && bus_wdata[OOM])) |=> pend_q[OOM]);
  // R10
  pool_rb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_PADR) |=> (pool_a_q == $past(bus_wdata)));
  // R11
  irq_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(pend_q & en_q));
endmodule

// File: tb/gfx_irq_regs_tb.sv
module gfx_irq_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ev_frame_done = 1'b0, ev_flush_done = 1'b0, ev_bin_oom = 1'b0;
  logic        irq;

  int n_chk = 0, n_bad = 0;
  logic [2:0]  m_pend, m_en;
  logic        m_cond, m_ga, m_gs, m_irq;
  logic [31:0] m_pa, m_ps;

  always #5 clk = ~clk;

  gfx_irq_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_frame_done(ev_frame_done),
    .ev_flush_done(ev_flush_done), .ev_bin_oom(ev_bin_oom), .irq(irq));

  function automatic logic [31:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return {29'd0, m_pend};
      3'd1, 3'd2: return {29'd0, m_en};
      3'd3: return m_pa;
      3'd4: return m_ps;
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_pend = '0; m_en = '0; m_cond = 1'b1; m_ga = 1'b0; m_gs = 1'b0;
    m_irq = 1'b0; m_pa = '0; m_ps = '0;
  endtask

  task automatic cycle(input string tag, input logic wr, input logic [2:0] a,
                       input logic [31:0] d, input logic er, input logic ef, input logic eo);
    logic [2:0] ack, ev, pn, en_n;
    logic ga, gs;
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d;
    ev_frame_done = er; ev_flush_done = ef; ev_bin_oom = eo;
    ev  = {eo, ef, er};
    ack = (wr && a == 3'd0) ? d[2:0] : 3'b0;
    pn[1:0] = (m_pend[1:0] & ~ack[1:0]) | ev[1:0];
    pn[2]   = eo | (~ack[2] & (m_pend[2] | m_cond));
    en_n = m_en;
    if (wr && a == 3'd1) en_n = en_n | d[2:0];
    if (wr && a == 3'd2) en_n = en_n & ~d[2:0];
    ga = m_ga | (wr && a == 3'd3);
    gs = m_gs | (wr && a == 3'd4);
    if (eo) begin m_cond = 1'b1; m_ga = 1'b0; m_gs = 1'b0; end
    else if (m_cond && ga && gs) begin m_cond = 1'b0; m_ga = 1'b0; m_gs = 1'b0; end
    else begin m_ga = ga; m_gs = gs; end
    if (wr && a == 3'd3) m_pa = d;
    if (wr && a == 3'd4) m_ps = d;
    m_pend = pn; m_en = en_n; m_irq = |(pn & en_n);
    @(posedge clk); #1;
    chk({tag, " R11 irq"}, {31'd0, irq}, {31'd0, m_irq});
    chk({tag, " readback"}, bus_rdata, exp_read(a));
  endtask

  task automatic rd(input string tag, input logic [2:0] a, input logic [31:0] exp);
    cycle(tag, 1'b0, a, 32'd0, 1'b0, 1'b0, 1'b0);
    chk(tag, bus_rdata, exp);
  endtask

  initial begin
    #1_500_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    void'($urandom(32'h5eed_1234));
    for (int a = 0; a < 5; a++) begin
      @(negedge clk); bus_addr = 3'(a); #1;
      chk("R1 reset readback", bus_rdata, 32'd0);
      chk("R1 reset irq", {31'd0, irq}, 32'd0);
    end
    @(negedge clk); rst_n = 1'b1;
    rd("R8 oom pending after reset", 3'd0, 32'd4);
    cycle("R5 set en", 1'b1, 3'd1, 32'hFFFF_FFFB, 1'b0, 1'b0, 1'b0);
    rd("R7 en via clear reg", 3'd2, 32'd3);
    rd("R7 en via set reg", 3'd1, 32'd3);
    cycle("R2 frame done", 1'b0, 3'd0, 32'd0, 1'b1, 1'b0, 1'b0);
    rd("R2 bit0 held", 3'd0, 32'd5);
    cycle("R2 flush done", 1'b0, 3'd0, 32'd0, 1'b0, 1'b1, 1'b0);
    rd("R2 bit1 held", 3'd0, 32'd7);
    cycle("R4 event vs ack", 1'b1, 3'd0, 32'd1, 1'b1, 1'b0, 1'b0);
    rd("R4 bit0 still pending", 3'd0, 32'd7);
    cycle("R3 ack bit0", 1'b1, 3'd0, 32'd1, 1'b0, 1'b0, 1'b0);
    rd("R3 bit0 cleared, others kept", 3'd0, 32'd6);
    rd("R3 bit0 stays clear", 3'd0, 32'd6);
    cycle("R3 ack bit1", 1'b1, 3'd0, 32'd2, 1'b0, 1'b0, 1'b0);
    chk("R11 irq low after acks", {31'd0, irq}, 32'd0);
    cycle("R5 zero write", 1'b1, 3'd1, 32'd0, 1'b0, 1'b0, 1'b0);
    rd("R5 mask unchanged", 3'd1, 32'd3);
    cycle("R6 clear bit0", 1'b1, 3'd2, 32'd1, 1'b0, 1'b0, 1'b0);
    rd("R6 mask after clear", 3'd2, 32'd2);
    cycle("R6 zero write", 1'b1, 3'd2, 32'd0, 1'b0, 1'b0, 1'b0);
    rd("R6 mask unchanged", 3'd1, 32'd2);
    cycle("R7 write to unused addr", 1'b1, 3'd6, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0);
    rd("R7 unused addr reads zero", 3'd6, 32'd0);
    cycle("R8 set oom enable", 1'b1, 3'd1, 32'd4, 1'b0, 1'b0, 1'b0);
    chk("R11 irq from oom", {31'd0, irq}, 32'd1);
    cycle("R8 ack oom", 1'b1, 3'd0, 32'd4, 1'b0, 1'b0, 1'b0);
    chk("R8 oom dips", bus_rdata, 32'd0);
    rd("R8 oom returns", 3'd0, 32'd4);
    cycle("R9 pool size", 1'b1, 3'd4, 32'h0001_0000, 1'b0, 1'b0, 1'b0);
    cycle("R9 pool addr", 1'b1, 3'd3, 32'h8000_1000, 1'b0, 1'b0, 1'b0);
    rd("R10 pool addr", 3'd3, 32'h8000_1000);
    rd("R10 pool size", 3'd4, 32'h0001_0000);
    cycle("R9 ack after pool", 1'b1, 3'd0, 32'd4, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) rd("R9 oom stays clear", 3'd0, 32'd0);
    cycle("R9 new oom event", 1'b0, 3'd0, 32'd0, 1'b0, 1'b0, 1'b1);
    rd("R9 oom back", 3'd0, 32'd4);
    cycle("R9 ack with live condition", 1'b1, 3'd0, 32'd4, 1'b0, 1'b0, 1'b0);
    rd("R9 condition restarted", 3'd0, 32'd4);
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] a;
      logic w;
      a = 3'($urandom_range(0, 7));
      w = ($urandom_range(0, 3) != 0);
      cycle(a == 3'd0 ? "R3 random status" : (a < 3'd3 ? "R7 random enable" : "R10 random pool"),
            w, a, ($urandom_range(0, 1) != 0) ? 32'($urandom_range(0, 7)) : $urandom(),
            $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0, $urandom_range(0, 63) == 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule